// File: doc/BRIEF.md
# Colour Bar Test Pattern Generator

This block is a video source for bring-up and link testing. While enabled it emits a continuous series of progressive frames on a streaming interface. The interface has a valid/ready handshake with a ready latency of one cycle. Each frame starts with a control packet that describes the frame size. A video packet follows it, with one beat per pixel and three colour planes side by side in each beat.

The picture is either eight vertical bars or a single flat colour. The bars cover every on/off combination of the three primaries at studio-range levels, and can be emitted as R'G'B' or as Y'CbCr. The flat colour comes from three sample registers. A small register port sets the enable bit, the pattern mode, the output colour space, the frame size and the flat colour. It also reports whether a frame is in flight. All settings are captured at the moment a frame starts.

Top module: `tpg_bars`

## Requirements
- R1: After reset the stream output is idle (valid low), the control register reads 0, the status register reads 0, width reads 640 and height reads 480.
- R2: Ready latency is one cycle: valid is high in a cycle only if ready was high in the cycle before. A cycle with ready low transfers nothing and loses no symbol.
- R3: Every frame opens with a 4-beat control packet. Beat 0 carries type 15 in plane 0 bits [3:0] with start-of-packet. The next three beats carry nine nibbles, one per plane, filling plane 0 first: width[15:12], width[11:8], width[7:4], width[3:0], height[15:12], height[11:8], height[7:4], height[3:0], then an interlace nibble of 0 (progressive). The last of these beats has end-of-packet.
- R4: The video packet follows at once. Its first beat carries type 0 with start-of-packet. Then width*height pixel beats follow in raster order, and end-of-packet is set on the last pixel only.
- R5: In bar mode with R'G'B' output, bar indices 0..7 show (R,G,B) on/off patterns 111, 110, 011, 010, 101, 100, 001, 000. An on component has value 180 and an off component has value 16. Plane 0 (bits [7:0]) is R, plane 1 is G and plane 2 is B.
- R6: In bar mode with Y'CbCr output, the (Y,Cb,Cr) values of bars 0..7 are (180,128,128), (162,44,142), (131,156,44), (112,72,58), (84,184,198), (65,100,212), (35,212,114) and (16,128,128). Plane 0 is Y, plane 1 is Cb and plane 2 is Cr.
- R7: The bar index of pixel column x is x / max(width/8, 1), capped at 7, so any remainder columns take the last bar.
- R8: In uniform mode every pixel equals the three colour registers: colour 0 on plane 0, colour 1 on plane 1 and colour 2 on plane 2. This holds in both colour-space settings.
- R9: No frame starts while the enable bit is 0. Clearing the enable bit during a frame lets that frame run to its end-of-packet, after which output stops.
- R10: Width, height, mode, colour space and colours are sampled when a frame starts. Writes made during a frame do not change that frame.
- R11: Register map (3-bit address, 16-bit data): 0 control (bit 0 enable, bit 1 uniform mode, bit 2 Y'CbCr output), 1 status (bit 0 frame in flight, read-only), 2 width, 3 height, 4/5/6 colour 0/1/2. Every writable register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| st_ready | input | 1 | Downstream ready, latency one |
| st_valid | output | 1 | Beat valid |
| st_data | output | 3*BPS | Three colour planes, plane 0 in the low bits |
| st_sop | output | 1 | Start of packet |
| st_eop | output | 1 | End of packet |

## Verification
The bench uses the default of 8 bits per sample, so the stated bar levels and the 4-bit header nibbles appear unscaled on the planes. It drives the frame size through the registers to small values: 19, 16, 8, 5 and 3 pixels wide. At these sizes every bar boundary can be checked pixel by pixel, and so can the remainder columns, the bar width clamped to 1 and the case with fewer than eight bars. Every frame is short, so back-to-back frames, a change of settings during a frame and randomly stalled ready can all be exercised within a few thousand cycles.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int REG_W = 16;
    localparam int DIM_W = 16;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STAT   = 3'd1;
    localparam logic [2:0] A_WIDTH  = 3'd2;
    localparam logic [2:0] A_HEIGHT = 3'd3;
    localparam logic [2:0] A_COL0   = 3'd4;
    localparam logic [2:0] A_COL1   = 3'd5;
    localparam logic [2:0] A_COL2   = 3'd6;

    localparam logic [3:0] TYPE_CTRL  = 4'hF;
    localparam logic [3:0] TYPE_VIDEO = 4'h0;
    localparam logic [3:0] IL_PROG    = 4'h0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHDR, ST_CW0, ST_CW1, ST_CW2, ST_VHDR, ST_PIX
    } seq_st_e;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int BPS   = 8,
    parameter int DEF_W = 640,
    parameter int DEF_H = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             busy,
    output logic             go,
    output logic             uni,
    output logic             ycc,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height,
    output logic [BPS-1:0]   col0,
    output logic [BPS-1:0]   col1,
    output logic [BPS-1:0]   col2
);
    typedef struct packed {
        logic             go;
        logic             uni;
        logic             ycc;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
        logic [BPS-1:0]   c0;
        logic [BPS-1:0]   c1;
        logic [BPS-1:0]   c2;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_CTRL: begin
                    r_d.go  = wdata[0];
                    r_d.uni = wdata[1];
                    r_d.ycc = wdata[2];
                end
                A_WIDTH:  r_d.w  = wdata;
                A_HEIGHT: r_d.h  = wdata;
                A_COL0:   r_d.c0 = wdata[BPS-1:0];
                A_COL1:   r_d.c1 = wdata[BPS-1:0];
                A_COL2:   r_d.c2 = wdata[BPS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{go: 1'b0, uni: 1'b0, ycc: 1'b0,
                     w: DIM_W'(DEF_W), h: DIM_W'(DEF_H),
                     c0: '0, c1: '0, c2: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:   rdata = REG_W'({r_q.ycc, r_q.uni, r_q.go});
            A_STAT:   rdata = REG_W'(busy);
            A_WIDTH:  rdata = r_q.w;
            A_HEIGHT: rdata = r_q.h;
            A_COL0:   rdata = REG_W'(r_q.c0);
            A_COL1:   rdata = REG_W'(r_q.c1);
            A_COL2:   rdata = REG_W'(r_q.c2);
            default:  rdata = '0;
        endcase
    end

    assign go     = r_q.go;
    assign uni    = r_q.uni;
    assign ycc    = r_q.ycc;
    assign width  = r_q.w;
    assign height = r_q.h;
    assign col0   = r_q.c0;
    assign col1   = r_q.c1;
    assign col2   = r_q.c2;

    // R11: a control write is visible on the enable output one cycle later
    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CTRL) |=> (go == $past(wdata[0])));
endmodule

// File: rtl/tpg_palette.sv
module tpg_palette #(
    parameter int BPS = 8
) (
    input  logic [2:0]       bar,
    input  logic             uni,
    input  logic             ycc,
    input  logic [BPS-1:0]   col0,
    input  logic [BPS-1:0]   col1,
    input  logic [BPS-1:0]   col2,
    output logic [3*BPS-1:0] pix
);
    localparam int SH = BPS - 8;

    function automatic logic [BPS-1:0] lvl(input logic [7:0] v);
        lvl = BPS'(v) << SH;
    endfunction

    logic [2:0]     on_rgb;     // {R,G,B}
    logic [BPS-1:0] rgb_pl [3];
    logic [7:0]     yv, cbv, crv;

    always_comb begin
        case (bar)
            3'd0: on_rgb = 3'b111;
            3'd1: on_rgb = 3'b110;
            3'd2: on_rgb = 3'b011;
            3'd3: on_rgb = 3'b010;
            3'd4: on_rgb = 3'b101;
            3'd5: on_rgb = 3'b100;
            3'd6: on_rgb = 3'b001;
            default: on_rgb = 3'b000;
        endcase
    end

    for (genvar p = 0; p < 3; p++) begin : g_plane
        assign rgb_pl[p] = on_rgb[2-p] ? lvl(8'd180) : lvl(8'd16);
    end

    always_comb begin
        case (bar)
            3'd0: begin yv = 8'd180; cbv = 8'd128; crv = 8'd128; end
            3'd1: begin yv = 8'd162; cbv = 8'd44;  crv = 8'd142; end
            3'd2: begin yv = 8'd131; cbv = 8'd156; crv = 8'd44;  end
            3'd3: begin yv = 8'd112; cbv = 8'd72;  crv = 8'd58;  end
            3'd4: begin yv = 8'd84;  cbv = 8'd184; crv = 8'd198; end
            3'd5: begin yv = 8'd65;  cbv = 8'd100; crv = 8'd212; end
            3'd6: begin yv = 8'd35;  cbv = 8'd212; crv = 8'd114; end
            default: begin yv = 8'd16; cbv = 8'd128; crv = 8'd128; end
        endcase
    end

    always_comb begin
        if (uni)      pix = {col2, col1, col0};
        else if (ycc) pix = {lvl(crv), lvl(cbv), lvl(yv)};
        else          pix = {rgb_pl[2], rgb_pl[1], rgb_pl[0]};
    end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int BPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             go,
    input  logic             uni,
    input  logic             ycc,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic [BPS-1:0]   col0,
    input  logic [BPS-1:0]   col1,
    input  logic [BPS-1:0]   col2,
    output logic             busy,
    output logic             valid,
    output logic [3*BPS-1:0] data,
    output logic             sop,
    output logic             eop
);
    localparam int DW = 3 * BPS;
    localparam logic [2:0] LAST_BAR = 3'd7;

    typedef struct packed {
        seq_st_e          st;
        logic [DIM_W-1:0] wl;
        logic [DIM_W-1:0] hl;
        logic [DIM_W-1:0] x;
        logic [DIM_W-1:0] y;
        logic [DIM_W-1:0] pos;
        logic [2:0]       bar;
        logic             uni;
        logic             ycc;
        logic [BPS-1:0]   c0;
        logic [BPS-1:0]   c1;
        logic [BPS-1:0]   c2;
        logic             valid;
        logic             sop;
        logic             eop;
        logic [DW-1:0]    data;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [DW-1:0] pack3(input logic [3:0] a, input logic [3:0] b,
                                            input logic [3:0] c);
        pack3 = {BPS'(c), BPS'(b), BPS'(a)};
    endfunction

    logic [DIM_W-1:0] bar_w;
    logic             last_x, last_y, pos_end;
    logic [DW-1:0]    pix;

    assign bar_w   = (s_q.wl[DIM_W-1:3] == '0) ? DIM_W'(1) : (s_q.wl >> 3);
    assign last_x  = (17'(s_q.x) + 17'd1) >= 17'(s_q.wl);
    assign last_y  = (17'(s_q.y) + 17'd1) >= 17'(s_q.hl);
    assign pos_end = (17'(s_q.pos) + 17'd1) >= 17'(bar_w);

    tpg_palette #(.BPS(BPS)) u_pal (
        .bar  (s_q.bar),
        .uni  (s_q.uni),
        .ycc  (s_q.ycc),
        .col0 (s_q.c0),
        .col1 (s_q.c1),
        .col2 (s_q.c2),
        .pix  (pix)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.sop   = 1'b0;
        s_d.eop   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    s_d.st  = ST_CHDR;
                    s_d.wl  = width;
                    s_d.hl  = height;
                    s_d.uni = uni;
                    s_d.ycc = ycc;
                    s_d.c0  = col0;
                    s_d.c1  = col1;
                    s_d.c2  = col2;
                    s_d.x   = '0;
                    s_d.y   = '0;
                    s_d.pos = '0;
                    s_d.bar = '0;
                end
            end
            ST_CHDR: if (ready) begin
                s_d.valid = 1'b1;
                s_d.sop   = 1'b1;
                s_d.data  = pack3(TYPE_CTRL, 4'h0, 4'h0);
                s_d.st    = ST_CW0;
            end
            ST_CW0: if (ready) begin
                s_d.valid = 1'b1;
                s_d.data  = pack3(s_q.wl[15:12], s_q.wl[11:8], s_q.wl[7:4]);
                s_d.st    = ST_CW1;
            end
            ST_CW1: if (ready) begin
                s_d.valid = 1'b1;
                s_d.data  = pack3(s_q.wl[3:0], s_q.hl[15:12], s_q.hl[11:8]);
                s_d.st    = ST_CW2;
            end
            ST_CW2: if (ready) begin
                s_d.valid = 1'b1;
                s_d.eop   = 1'b1;
                s_d.data  = pack3(s_q.hl[7:4], s_q.hl[3:0], IL_PROG);
                s_d.st    = ST_VHDR;
            end
            ST_VHDR: if (ready) begin
                s_d.valid = 1'b1;
                s_d.sop   = 1'b1;
                s_d.data  = pack3(TYPE_VIDEO, 4'h0, 4'h0);
                s_d.st    = ST_PIX;
            end
            ST_PIX: if (ready) begin
                s_d.valid = 1'b1;
                s_d.data  = pix;
                s_d.eop   = last_x && last_y;
                if (last_x) begin
                    s_d.x   = '0;
                    s_d.pos = '0;
                    s_d.bar = '0;
                    s_d.y   = s_q.y + 1'b1;
                    if (last_y) s_d.st = ST_IDLE;
                end else begin
                    s_d.x = s_q.x + 1'b1;
                    if (pos_end) begin
                        s_d.pos = '0;
                        if (s_q.bar != LAST_BAR) s_d.bar = s_q.bar + 1'b1;
                    end else begin
                        s_d.pos = s_q.pos + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = (s_q.st != ST_IDLE);
    assign valid = s_q.valid;
    assign data  = s_q.data;
    assign sop   = s_q.sop;
    assign eop   = s_q.eop;

    // R2: a beat may only appear in the cycle after ready was high
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> $past(ready));

    // R2: with ready low the sequence holds and nothing is sent
    assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && !ready) |=> ($stable(s_q.st) && $stable(s_q.x) && !s_q.valid));

    // R4: packet markers only travel with a valid beat
    assert_markers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sop || s_q.eop) |-> s_q.valid);

    // R9: leaving the pixel phase always coincides with the closing beat
    assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st) == ST_PIX && s_q.st == ST_IDLE) |-> (s_q.valid && s_q.eop));

    // R10: captured settings stay fixed for the whole frame
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st) != ST_IDLE && s_q.st != ST_IDLE) |->
        ($stable(s_q.wl) && $stable(s_q.hl) && $stable(s_q.uni) && $stable(s_q.ycc)));

    // R7: within a line the bar index never steps backwards
    assert_bar_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PIX && $past(s_q.st) == ST_PIX && s_q.x != '0) |->
        (s_q.bar >= $past(s_q.bar)));
endmodule

// File: rtl/tpg_bars.sv
module tpg_bars
    import tpg_pkg::*;
#(
    parameter int BPS   = 8,
    parameter int DEF_W = 640,
    parameter int DEF_H = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             st_ready,
    output logic             st_valid,
    output logic [3*BPS-1:0] st_data,
    output logic             st_sop,
    output logic             st_eop
);
    logic             go, uni, ycc, busy;
    logic [DIM_W-1:0] width, height;
    logic [BPS-1:0]   col0, col1, col2;

    tpg_regs #(.BPS(BPS), .DEF_W(DEF_W), .DEF_H(DEF_H)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .busy   (busy),
        .go     (go),
        .uni    (uni),
        .ycc    (ycc),
        .width  (width),
        .height (height),
        .col0   (col0),
        .col1   (col1),
        .col2   (col2)
    );

    tpg_seq #(.BPS(BPS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (st_ready),
        .go     (go),
        .uni    (uni),
        .ycc    (ycc),
        .width  (width),
        .height (height),
        .col0   (col0),
        .col1   (col1),
        .col2   (col2),
        .busy   (busy),
        .valid  (st_valid),
        .data   (st_data),
        .sop    (st_sop),
        .eop    (st_eop)
    );
endmodule

// File: tb/sim_tpg_bars.sv
module sim_tpg_bars;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        st_ready = 1'b1;
    logic        st_valid;
    logic [23:0] st_data;
    logic        st_sop, st_eop;

    int checks = 0;
    int errors = 0;
    int nb = 0;
    int lat_err = 0;
    int rmode = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [25:0] cap [0:1023];

    always #10 clk = ~clk;

    tpg_bars u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_ready(st_ready),
        .st_valid(st_valid), .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
    );

    // monitor and ready driver, both away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (st_valid) begin
                if (!st_ready) lat_err++;
                if (nb < 1024) cap[nb] = {st_sop, st_eop, st_data};
                nb++;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            st_ready = (rmode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [23:0] pk(input int a, input int b, input int c);
        return {4'h0, 4'(c), 4'h0, 4'(b), 4'h0, 4'(a)};
    endfunction

    function automatic logic [23:0] rgb_bar(input int b);
        bit r, g, bl;
        r  = (b == 0 || b == 1 || b == 4 || b == 5);
        g  = (b <= 3);
        bl = (b % 2 == 0);
        return {bl ? 8'd180 : 8'd16, g ? 8'd180 : 8'd16, r ? 8'd180 : 8'd16};
    endfunction

    function automatic logic [23:0] ycc_bar(input int b);
        case (b)
            0: return {8'd128, 8'd128, 8'd180};
            1: return {8'd142, 8'd44,  8'd162};
            2: return {8'd44,  8'd156, 8'd131};
            3: return {8'd58,  8'd72,  8'd112};
            4: return {8'd198, 8'd184, 8'd84};
            5: return {8'd212, 8'd100, 8'd65};
            6: return {8'd114, 8'd212, 8'd35};
            default: return {8'd128, 8'd128, 8'd16};
        endcase
    endfunction

    function automatic logic [25:0] exp_beat(input int i, input int w, input int h,
                                             input bit uni, input bit ycc,
                                             input logic [7:0] c0, input logic [7:0] c1,
                                             input logic [7:0] c2);
        logic [23:0] d;
        bit s, e;
        int p, x, bw, b;
        s = 0; e = 0; d = '0;
        if (i == 0) begin s = 1; d = 24'h00000F; end
        else if (i == 1) d = pk(w >> 12, w >> 8, w >> 4);
        else if (i == 2) d = pk(w, h >> 12, h >> 8);
        else if (i == 3) begin d = pk(h >> 4, h, 0); e = 1; end
        else if (i == 4) s = 1;
        else begin
            p = i - 5;
            x = p % w;
            e = (p == w * h - 1);
            if (uni) d = {c2, c1, c0};
            else begin
                bw = w / 8;
                if (bw == 0) bw = 1;
                b = x / bw;
                if (b > 7) b = 7;
                d = ycc ? ycc_bar(b) : rgb_bar(b);
            end
        end
        return {s, e, d};
    endfunction

    task automatic run_frame(input string rq, input int w, input int h, input bit uni,
                             input bit ycc, input logic [7:0] c0, input logic [7:0] c1,
                             input logic [7:0] c2, input int rm, input bit mid);
        int base, n_exp, guard;
        logic [15:0] st;
        logic [25:0] ex;
        string tag;
        rmode = rm;
        lat_err = 0;
        wr_reg(3'd2, 16'(w));
        wr_reg(3'd3, 16'(h));
        wr_reg(3'd4, {8'h0, c0});
        wr_reg(3'd5, {8'h0, c1});
        wr_reg(3'd6, {8'h0, c2});
        base = nb;
        wr_reg(3'd0, {13'd0, ycc, uni, 1'b1});
        guard = 0;
        do begin rd_reg(3'd1, st); guard++; end while (st[0] == 1'b0 && guard < 200);
        wr_reg(3'd0, {13'd0, ycc, uni, 1'b0});
        if (mid) begin
            // R10: settings changed while the frame is in flight
            wr_reg(3'd0, 16'h0006);
            wr_reg(3'd2, 16'd12);
            wr_reg(3'd4, 16'h00AA);
        end
        guard = 0;
        do begin rd_reg(3'd1, st); guard++; end while (st[0] == 1'b1 && guard < 5000);
        repeat (8) @(negedge clk);
        n_exp = 5 + w * h;
        check(nb - base == n_exp, "R9 beat count per enabled frame", nb - base, n_exp);
        for (int i = 0; i < n_exp; i++) begin
            ex = exp_beat(i, w, h, uni, ycc, c0, c1, c2);
            tag = (i < 4) ? "R3 control packet" : (i == 4) ? "R4 video header" : rq;
            check(cap[base + i] == ex, tag, 32'(cap[base + i]), 32'(ex));
        end
        check(lat_err == 0, "R2 valid only after ready", lat_err, 0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check(st_valid == 1'b0, "R1 valid low after reset", st_valid, 0);
        rd_reg(3'd0, v); check(v == 16'd0, "R1 control reset", v, 0);
        rd_reg(3'd1, v); check(v == 16'd0, "R1 status reset", v, 0);
        rd_reg(3'd2, v); check(v == 16'd640, "R1 width reset", v, 640);
        rd_reg(3'd3, v); check(v == 16'd480, "R1 height reset", v, 480);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr_reg(3'd4, 16'h005A); rd_reg(3'd4, v); check(v == 16'h005A, "R11 colour 0 readback", v, 16'h5A);
        wr_reg(3'd6, 16'h00C3); rd_reg(3'd6, v); check(v == 16'h00C3, "R11 colour 2 readback", v, 16'hC3);
        wr_reg(3'd3, 16'h1234); rd_reg(3'd3, v); check(v == 16'h1234, "R11 height readback", v, 16'h1234);
        wr_reg(3'd0, 16'h0006); rd_reg(3'd0, v); check(v == 16'h0006, "R11 control readback", v, 6);
        wr_reg(3'd1, 16'h0001); rd_reg(3'd1, v); check(v == 16'h0000, "R11 status is read-only", v, 0);
        wr_reg(3'd0, 16'h0000);
    endtask

    task automatic t_idle;
        int base;
        base = nb;
        rmode = 0;
        repeat (40) @(negedge clk);
        check(nb == base, "R9 no output while disabled", nb - base, 0);
    endtask

    // R5 and R7: remainder columns on a 19-wide frame
    task automatic t_rgb_bars;
        run_frame("R5 R7 rgb bar pixel", 19, 2, 0, 0, 8'h0, 8'h0, 8'h0, 0, 0);
    endtask

    // R6 and R2: stalled ready
    task automatic t_ycc_bars;
        run_frame("R6 ycc bar pixel", 16, 2, 0, 1, 8'h0, 8'h0, 8'h0, 1, 0);
    endtask

    // R8: flat colour overrides the colour-space setting
    task automatic t_uniform;
        run_frame("R8 uniform pixel", 5, 3, 1, 1, 8'h11, 8'h22, 8'h33, 1, 0);
    endtask

    // R7: width under 8 gives bar width 1
    task automatic t_narrow;
        run_frame("R7 narrow bar pixel", 3, 1, 0, 0, 8'h0, 8'h0, 8'h0, 0, 0);
    endtask

    // R10: mid-frame writes do not alter the frame; the next frame uses them
    task automatic t_sample;
        run_frame("R10 frame uses start settings", 8, 2, 0, 0, 8'h0, 8'h0, 8'h0, 1, 1);
        run_frame("R10 next frame uses new settings", 12, 1, 1, 0, 8'h44, 8'h55, 8'h66, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_idle;
        t_rgb_bars;
        t_ycc_bars;
        t_uniform;
        t_narrow;
        t_sample;
        t_idle;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule